// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a slave peripheral on a 16-bit word-addressed load/store bus that hands single keystrokes to software. A keystroke source presents an 8-bit character code together with a one-cycle valid strobe. The port keeps that character, raises a ready flag, and refuses any later keystroke until software takes the character by reading the data word. Software learns that a character is waiting either by polling the status word or through a level interrupt request. The request is active while the ready flag and a software-written enable bit are both set.

The bus side is a plain read/write strobe pair with an address and a write word. The read word comes combinationally from the addressed register in the cycle of the read. Any side effect of that read is applied at the clock edge that ends the cycle. The reset input is asynchronous and active low. Its release is synchronised inside the block, so registers leave reset two clock edges after the input rises.

Top module: `kbd_input_port`

## Requirements
- R1: The status word is decoded at address 0xFE00 and the data word at 0xFE02. A read of any other address returns zero and changes no state.
- R2: A keystroke accepted while the port is empty places its code in data bits [7:0], and data bits [15:8] always read as zero.
- R3: Status bit 15 (ready) reads as one from the cycle after a keystroke is accepted.
- R4: While ready is one, further keystrokes are dropped and the held character is unchanged.
- R5: A bus read of the data word clears ready at the end of that cycle, and the next keystroke is accepted again.
- R6: Status bit 14 (interrupt enable) takes the value of write-data bit 14 on any bus write to the status word, and reads back.
- R7: The irq output is one exactly when ready and interrupt enable are both one.
- R8: Status bits [13:0] read as zero. Writes to status bit 15 and writes to the data word have no effect.
- R9: Reading the status word has no side effect on ready or on the held character.
- R10: Reset clears ready, interrupt enable and the held character, so both words read zero.
- R11: A keystroke in the same cycle as a data-word read is accepted: the read returns the old character, ready stays one, and the new character is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Word address of the bus access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, zero when nothing is decoded |
| key_valid | input | 1 | One-cycle strobe marking a new keystroke |
| key_code | input | 8 | Character code of the keystroke |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, 8-bit characters, and the status and data words at 0xFE00 and 0xFE02. This places the zero-filled upper byte of the data word, and the unused status bits below the enable bit, at positions the bench can see directly. Near-miss addresses such as 0xFE03 and 0xFE04 are also reachable, to show that decoding is exact. The same settings bring within reach the cycle where a data read and a keystroke meet, a reset asserted while a character is held, and status writes that try to set the ready bit.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned KBD_READY_BIT = 15;
  localparam int unsigned KBD_IE_BIT    = 14;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_DATA   = 2'd2
  } kbd_sel_e;
endpackage

// File: rtl/kbd_rst_sync.sv
module kbd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
  import kbd_pkg::*;
#(
  parameter int unsigned    ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output kbd_sel_e          sel,
  output logic              data_rd,
  output logic              status_wr
);
  always_comb begin
    if (addr == STATUS_ADDR)    sel = SEL_STATUS;
    else if (addr == DATA_ADDR) sel = SEL_DATA;
    else                        sel = SEL_NONE;
  end

  assign data_rd   = rd && (sel == SEL_DATA);
  assign status_wr = wr && (sel == SEL_STATUS);
endmodule

// File: rtl/kbd_char_hold.sv
module kbd_char_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_code,
  input  logic              data_rd,
  output logic              ready,
  output logic [CHAR_W-1:0] char_q
);
  logic              ready_q;
  logic              ready_d;
  logic [CHAR_W-1:0] char_d;
  logic              accept;
  logic              char_en;

  // Capture allowed when empty, or when the held char is being taken now
  always_comb begin
    accept  = key_valid && (!ready_q || data_rd);
    char_en = accept;
    char_d  = key_code;
    if (accept)       ready_d = 1'b1;
    else if (data_rd) ready_d = 1'b0;
    else              ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else begin
      ready_q <= ready_d;
      if (char_en) char_q <= char_d;
    end
  end

  assign ready = ready_q;

  AST_HOLD_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !data_rd) |=> ($stable(char_q) && ready_q)); // R4
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && data_rd && !key_valid) |=> !ready_q); // R5
  AST_READ_AND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && key_valid) |=> (ready_q && char_q == $past(key_code))); // R11
  AST_NO_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(char_q)); // R2
  AST_SET_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> ready_q); // R3
endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic status_wr,
  input  logic ie_wdata,
  input  logic ready,
  output logic ie,
  output logic irq
);
  logic ie_q;
  logic ie_d;
  logic ie_en;

  always_comb begin
    ie_en = status_wr;
    ie_d  = ie_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end

  assign ie  = ie_q;
  assign irq = ready && ie_q;

  AST_IE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> (ie_q == $past(ie_wdata))); // R6
  AST_IE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !status_wr |=> $stable(ie_q)); // R6
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_pkg::*;
#(
  parameter int unsigned    ADDR_W      = 16,
  parameter int unsigned    BUS_W       = 16,
  parameter int unsigned    CHAR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hFE02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_code,
  output logic              irq
);
  localparam int unsigned PAD_W = BUS_W - CHAR_W;

  logic              rst_sync_n;
  kbd_sel_e          sel;
  logic              data_rd;
  logic              status_wr;
  logic              ready;
  logic              ie;
  logic [CHAR_W-1:0] char_q;
  logic [BUS_W-1:0]  status_word;
  logic [BUS_W-1:0]  data_word;

  kbd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kbd_addr_decode #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .DATA_ADDR   (DATA_ADDR)
  ) u_decode (
    .addr      (bus_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .sel       (sel),
    .data_rd   (data_rd),
    .status_wr (status_wr)
  );

  kbd_char_hold #(
    .CHAR_W (CHAR_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .key_valid (key_valid),
    .key_code  (key_code),
    .data_rd   (data_rd),
    .ready     (ready),
    .char_q    (char_q)
  );

  kbd_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .status_wr (status_wr),
    .ie_wdata  (bus_wdata[KBD_IE_BIT]),
    .ready     (ready),
    .ie        (ie),
    .irq       (irq)
  );

  always_comb begin
    status_word                = '0;
    status_word[KBD_READY_BIT] = ready;
    status_word[KBD_IE_BIT]    = ie;
    data_word                  = {{PAD_W{1'b0}}, char_q};
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: bus_rdata = status_word;
      SEL_DATA:   bus_rdata = data_word;
      default:    bus_rdata = '0;
    endcase
  end

  AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_DATA) |-> (bus_rdata[BUS_W-1:CHAR_W] == '0)); // R2
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_STATUS) |-> (bus_rdata[KBD_IE_BIT-1:0] == '0)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0)); // R1
  AST_STATUS_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && sel == SEL_STATUS && !key_valid) |=> $stable(ready)); // R9
  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (bus_rdata == status_word || sel != SEL_STATUS) && ready && ie); // R7
endmodule

// File: tb/kbd_input_port_tb_top.sv
module kbd_input_port_tb_top;
  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_DATA = 16'hFE02;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        key_valid = 1'b0;
  logic [7:0]  key_code = '0;
  logic        irq;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  kbd_input_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .key_valid (key_valid),
    .key_code  (key_code),
    .irq       (irq)
  );

  // Monitor: pops expected read data in the middle of each read cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: read got %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (bus_rdata !== e.val) begin
          failures++;
          $display("FAIL %s: addr %h read %h expected %h", e.tag, bus_addr, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic bus_read(input logic [15:0] a, input logic [15:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    sb_q.push_back(e);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic press(input logic [7:0] c);
    @(posedge clk); #1;
    key_code = c; key_valid = 1'b1;
    @(posedge clk); #1;
    key_valid = 1'b0;
  endtask

  task automatic read_with_key(input logic [15:0] exp, input logic [7:0] c, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    @(posedge clk); #1;
    bus_addr = A_DATA; bus_rd = 1'b1; key_code = c; key_valid = 1'b1;
    sb_q.push_back(e);
    @(posedge clk); #1;
    bus_rd = 1'b0; key_valid = 1'b0;
  endtask

  task automatic check_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s: irq %b expected %b", tag, irq, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R10 reset state
    bus_read(A_STAT, 16'h0000, "R10 status after reset");
    bus_read(A_DATA, 16'h0000, "R10 data after reset");
    check_irq(1'b0, "R10 irq after reset");
    // R2 R3 capture
    press(8'h41);
    bus_read(A_STAT, 16'h8000, "R3 ready set");
    bus_read(A_STAT, 16'h8000, "R9 status read no side effect");
    check_irq(1'b0, "R7 irq off with enable clear");
    // R4 drop while ready
    press(8'h42);
    bus_read(A_DATA, 16'h0041, "R4 held char kept, R2 upper zero");
    bus_read(A_STAT, 16'h0000, "R5 ready cleared by data read");
    // R8 writes without effect
    bus_write(A_DATA, 16'h1234);
    bus_read(A_DATA, 16'h0041, "R8 data write ignored");
    bus_write(A_STAT, 16'h8000);
    bus_read(A_STAT, 16'h0000, "R8 ready bit write ignored");
    // R6 R7 interrupt enable
    bus_write(A_STAT, 16'h4000);
    bus_read(A_STAT, 16'h4000, "R6 enable readback");
    check_irq(1'b0, "R7 irq off without ready");
    press(8'h43);
    check_irq(1'b1, "R7 irq on with ready and enable");
    bus_read(A_STAT, 16'hC000, "R3 R6 status both bits");
    bus_read(A_DATA, 16'h0043, "R5 re-enabled capture of next key");
    check_irq(1'b0, "R7 irq drops after data read");
    // R11 simultaneous read and keystroke
    press(8'h44);
    read_with_key(16'h0044, 8'h45, "R11 read returns old char");
    bus_read(A_STAT, 16'hC000, "R11 ready stays set");
    bus_read(A_DATA, 16'h0045, "R11 new char held");
    // R1 decode and R8 low status bits
    press(8'h46);
    bus_read(16'hFE04, 16'h0000, "R1 unmapped 0xFE04 reads zero");
    bus_read(16'hFE03, 16'h0000, "R1 unmapped 0xFE03 reads zero");
    bus_write(A_STAT, 16'h3FFF);
    bus_read(A_STAT, 16'h8000, "R8 low bits zero, R6 enable written zero");
    check_irq(1'b0, "R6 irq masked after enable cleared");
    bus_read(A_DATA, 16'h0046, "R1 unmapped reads left char held");
    // R10 reset while holding a char
    press(8'h47);
    bus_write(A_STAT, 16'h4000);
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1;
    check_irq(1'b0, "R10 irq cleared in reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bus_read(A_STAT, 16'h0000, "R10 status after mid-run reset");
    bus_read(A_DATA, 16'h0000, "R10 data after mid-run reset");
    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d reads left, expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule